// File: doc/BRIEF.md
# Sixteen-Bit ALU with Registered Flags

This block is the arithmetic and logic stage of a small 16-bit processor datapath. Each cycle it takes an 8-bit opcode, two 16-bit source operands and a shift amount drawn from the instruction's immediate field. It then produces, within the same cycle, a 16-bit result, a write-enable for the destination register and the next value of the five status flags. The flags are captured in a register on every rising clock edge. The register is presented as a 16-bit flag word.

The operations are add, subtract, increment, decrement, negate, bitwise AND/OR/XOR/NOT, and logical left and right shifts. Compare and test run the subtract and AND paths but only update the flags and never write a result. Two further opcodes set and clear the interrupt-enable bit and touch nothing else. Every opcode outside this set is treated as foreign to the ALU: no write, and all flags hold.

The block has no state machine. Its only storage is the flag register, which holds its value on an unrecognised opcode and otherwise loads the computed flag set.

Top module: `alu16_flags`

## Requirements
- R1: After reset the flag word reads 0x0000.
- R2: Opcode 0x05 gives result = A + B (mod 2^16) with write-enable high. C is the carry out of bit 15. V is set when A and B have the same sign and the result sign differs from it.
- R3: Opcode 0x06 gives result = A − B with write-enable high. C is set on a borrow (A < B unsigned). V is set when the signs of A and B differ and the result sign differs from A.
- R4: Opcode 0x17 sets the flags as a subtract of B from A, and opcode 0x18 sets them as A AND B. Both keep write-enable low.
- R5: Opcodes 0x12, 0x13, 0x14 and 0x19 give AND, OR, XOR and NOT of A (NOT ignores B) with write-enable high, and clear both V and C.
- R6: Opcode 0x15 shifts A left and opcode 0x16 shifts A right logically (zero fill), by the shift amount, with write-enable high.
  - An amount of 16 or more yields 0.
  - C is the last bit shifted out, or 0 for an amount of 0.
  - V is cleared.
- R7: Opcode 0x1A gives A + 1 and opcode 0x1B gives A − 1, with C and V taken as for add and subtract with B = 1. Opcode 0x1C gives 0 − A, with C and V taken as for a subtract from zero. All three have write-enable high.
- R8: For every ALU opcode, including compare and test, N equals result bit 15 and Z is set exactly when the 16-bit result is zero.
- R9: Opcode 0x10 sets I and opcode 0x11 clears I, with write-enable low and V, C, N and Z unchanged. No other opcode changes I.
- R10: Any opcode not named in R2–R9 gives write-enable low and leaves the whole flag word unchanged.
- R11: The flag word holds I at bit 4, V at bit 3, C at bit 2, N at bit 1 and Z at bit 0, and its upper 11 bits always read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the flag register loads on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of the flag register |
| opcode | input | 8 | Operation select |
| src_a | input | 16 | First source operand |
| src_b | input | 16 | Second source operand |
| shamt | input | 16 | Shift amount from the immediate field |
| result | output | 16 | Combinational operation result |
| result_we | output | 1 | Destination write-enable |
| flags_next | output | 5 | Flag set to be loaded at the next edge {I,V,C,N,Z} |
| flag_word | output | 16 | Registered flag word |

## Verification
The bench builds the block with its default parameters: a 16-bit data width and a full 16-bit shift-amount field. Because the shift field is that wide, random amounts land mostly far above the data width. The bench therefore adds directed amounts of 0, 1, 15, 16 and 17, which bring the carry-out edge at exactly 16 within reach. Random operands are mixed with sign-boundary values (0x7FFF, 0x8000, 0xFFFF, 0), so that the overflow and borrow corners of add, subtract, negate and the increment and decrement wrap are all reached.

// File: rtl/alu16_pkg.sv
package alu16_pkg;

    localparam logic [7:0] OP_EI   = 8'h10;
    localparam logic [7:0] OP_DI   = 8'h11;
    localparam logic [7:0] OP_ADD  = 8'h05;
    localparam logic [7:0] OP_SUB  = 8'h06;
    localparam logic [7:0] OP_AND  = 8'h12;
    localparam logic [7:0] OP_OR   = 8'h13;
    localparam logic [7:0] OP_XOR  = 8'h14;
    localparam logic [7:0] OP_SHL  = 8'h15;
    localparam logic [7:0] OP_SHR  = 8'h16;
    localparam logic [7:0] OP_CMP  = 8'h17;
    localparam logic [7:0] OP_TST  = 8'h18;
    localparam logic [7:0] OP_NOT  = 8'h19;
    localparam logic [7:0] OP_INC  = 8'h1A;
    localparam logic [7:0] OP_DEC  = 8'h1B;
    localparam logic [7:0] OP_NEG  = 8'h1C;

    localparam int FLAG_BITS = 5;

    // packed order puts ie at bit 4 down to zf at bit 0
    typedef struct packed {
        logic ie;
        logic vf;
        logic cf;
        logic nf;
        logic zf;
    } flags_t;

    typedef enum logic [1:0] {
        LG_AND = 2'd0,
        LG_OR  = 2'd1,
        LG_XOR = 2'd2,
        LG_NOT = 2'd3
    } logic_sel_e;

    function automatic logic touches_flags(input logic [7:0] op);
        case (op)
            OP_EI, OP_DI, OP_ADD, OP_SUB, OP_AND, OP_OR, OP_XOR, OP_SHL,
            OP_SHR, OP_CMP, OP_TST, OP_NOT, OP_INC, OP_DEC, OP_NEG:
                touches_flags = 1'b1;
            default: touches_flags = 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/alu16_addsub.sv
module alu16_addsub #(
    parameter int W = 16
) (
    input  logic [W-1:0] op_a,
    input  logic [W-1:0] op_b,
    input  logic         do_sub,
    output logic [W-1:0] sum,
    output logic         carry,
    output logic         ovf
);
    logic [W:0] wide;

    always_comb begin
        if (do_sub) begin
            wide = {1'b0, op_a} - {1'b0, op_b};
        end else begin
            wide = {1'b0, op_a} + {1'b0, op_b};
        end
        sum   = wide[W-1:0];
        // top bit is carry for add, borrow for subtract
        carry = wide[W];
        if (do_sub) begin
            ovf = (op_a[W-1] != op_b[W-1]) && (wide[W-1] != op_a[W-1]);
        end else begin
            ovf = (op_a[W-1] == op_b[W-1]) && (wide[W-1] != op_a[W-1]);
        end
    end
endmodule

// File: rtl/alu16_logic.sv
module alu16_logic
    import alu16_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [W-1:0] op_a,
    input  logic [W-1:0] op_b,
    input  logic_sel_e   sel,
    output logic [W-1:0] res
);
    always_comb begin
        unique case (sel)
            LG_AND:  res = op_a & op_b;
            LG_OR:   res = op_a | op_b;
            LG_XOR:  res = op_a ^ op_b;
            LG_NOT:  res = ~op_a;
            default: res = '0;
        endcase
    end
endmodule

// File: rtl/alu16_shift.sv
module alu16_shift #(
    parameter int W     = 16,
    parameter int AMT_W = 16
) (
    input  logic [W-1:0]     op_a,
    input  logic [AMT_W-1:0] amt,
    input  logic             go_left,
    output logic [W-1:0]     res,
    output logic             cout
);
    localparam int DW = 2 * W;

    logic [DW-1:0] lwide;
    logic [DW-1:0] rwide;

    always_comb begin
        // the extra half catches the last bit to leave the word
        lwide = {{W{1'b0}}, op_a} << amt;
        rwide = {op_a, {W{1'b0}}} >> amt;
        if (go_left) begin
            res  = lwide[W-1:0];
            cout = lwide[W];
        end else begin
            res  = rwide[DW-1:W];
            cout = rwide[W-1];
        end
    end
endmodule

// File: rtl/alu16_flags.sv
module alu16_flags
    import alu16_pkg::*;
#(
    parameter int W     = 16,
    parameter int AMT_W = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [7:0]           opcode,
    input  logic [W-1:0]         src_a,
    input  logic [W-1:0]         src_b,
    input  logic [AMT_W-1:0]     shamt,
    output logic [W-1:0]         result,
    output logic                 result_we,
    output logic [FLAG_BITS-1:0] flags_next,
    output logic [W-1:0]         flag_word
);
    localparam int PAD_W = W - FLAG_BITS;

    flags_t     flags_q;
    flags_t     nx;
    logic [W-1:0] as_a, as_b, as_r;
    logic         as_sub, as_c, as_v;
    logic [W-1:0] lg_r;
    logic_sel_e   lg_sel;
    logic [W-1:0] sh_r;
    logic         sh_c, sh_left;
    logic [W-1:0] res;
    logic         we, take_nz;

    // operand steering for the shared adder and helpers
    always_comb begin
        as_a    = src_a;
        as_b    = src_b;
        as_sub  = 1'b0;
        lg_sel  = LG_AND;
        sh_left = (opcode == OP_SHL);
        case (opcode)
            OP_SUB, OP_CMP: as_sub = 1'b1;
            OP_INC: as_b = W'(1);
            OP_DEC: begin as_b = W'(1); as_sub = 1'b1; end
            OP_NEG: begin as_a = '0; as_b = src_a; as_sub = 1'b1; end
            OP_OR:  lg_sel = LG_OR;
            OP_XOR: lg_sel = LG_XOR;
            OP_NOT: lg_sel = LG_NOT;
            default: ;
        endcase
    end

    alu16_addsub #(.W(W)) u_addsub (
        .op_a(as_a), .op_b(as_b), .do_sub(as_sub),
        .sum(as_r), .carry(as_c), .ovf(as_v)
    );

    alu16_logic #(.W(W)) u_logic (
        .op_a(src_a), .op_b(src_b), .sel(lg_sel), .res(lg_r)
    );

    alu16_shift #(.W(W), .AMT_W(AMT_W)) u_shift (
        .op_a(src_a), .amt(shamt), .go_left(sh_left),
        .res(sh_r), .cout(sh_c)
    );

    // result selection and next-flag computation
    always_comb begin
        res     = '0;
        we      = 1'b0;
        take_nz = 1'b0;
        nx      = flags_q;
        case (opcode)
            OP_ADD, OP_SUB, OP_INC, OP_DEC, OP_NEG: begin
                res = as_r; we = 1'b1; take_nz = 1'b1;
                nx.cf = as_c; nx.vf = as_v;
            end
            OP_CMP: begin
                res = as_r; take_nz = 1'b1;
                nx.cf = as_c; nx.vf = as_v;
            end
            OP_AND, OP_OR, OP_XOR, OP_NOT: begin
                res = lg_r; we = 1'b1; take_nz = 1'b1;
                nx.cf = 1'b0; nx.vf = 1'b0;
            end
            OP_TST: begin
                res = lg_r; take_nz = 1'b1;
                nx.cf = 1'b0; nx.vf = 1'b0;
            end
            OP_SHL, OP_SHR: begin
                res = sh_r; we = 1'b1; take_nz = 1'b1;
                nx.cf = sh_c; nx.vf = 1'b0;
            end
            OP_EI: nx.ie = 1'b1;
            OP_DI: nx.ie = 1'b0;
            default: ;
        endcase
        if (take_nz) begin
            nx.nf = res[W-1];
            nx.zf = (res == '0);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flags_q <= '0;
        end else begin
            flags_q <= nx;
        end
    end

    assign result     = res;
    assign result_we  = we;
    assign flags_next = nx;
    assign flag_word  = {{PAD_W{1'b0}}, flags_q};

    // R4: compare and test never write a destination
    p_flag_only_nowrite_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (opcode == OP_CMP || opcode == OP_TST) |-> !result_we);

    // R10: foreign opcodes hold the whole flag word
    p_foreign_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !touches_flags(opcode) |=> $stable(flag_word));

    // R9: enable sets I and keeps the arithmetic flags
    p_ei_sets_i_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (opcode == OP_EI) |=> (flag_word[4] && flag_word[3:0] == $past(flag_word[3:0])));

    // R9: I is only changed by the enable and disable opcodes
    p_i_owner_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (opcode != OP_EI && opcode != OP_DI) |=> $stable(flag_word[4]));

    // R8: Z follows a zero result on written operations
    p_zero_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (result_we && result == '0) |=> flag_word[0]);

    // R11: padding above the flags stays clear
    p_pad_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
        flag_word[W-1:FLAG_BITS] == '0);

endmodule

// File: tb/tb_alu16_flags.sv
module tb_alu16_flags;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  opcode = 8'h00;
    logic [15:0] src_a = '0, src_b = '0, shamt = '0;
    logic [15:0] result;
    logic        result_we;
    logic [4:0]  flags_next;
    logic [15:0] flag_word;

    int n_run = 0;
    int n_fail = 0;
    logic [4:0] mflags;   // model {I,V,C,N,Z}

    always #10 clk = ~clk;   // 50 MHz

    alu16_flags dut (
        .clk(clk), .rst_n(rst_n), .opcode(opcode), .src_a(src_a),
        .src_b(src_b), .shamt(shamt), .result(result),
        .result_we(result_we), .flags_next(flags_next), .flag_word(flag_word)
    );

    function automatic string tag_of(input logic [7:0] op);
        case (op)
            8'h05: return "R2";
            8'h06: return "R3";
            8'h17, 8'h18: return "R4";
            8'h12, 8'h13, 8'h14, 8'h19: return "R5";
            8'h15, 8'h16: return "R6";
            8'h1A, 8'h1B, 8'h1C: return "R7";
            8'h10, 8'h11: return "R9";
            default: return "R10";
        endcase
    endfunction

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // reference model; updates the model flags
    task automatic model(input logic [7:0] op, input logic [15:0] a, input logic [15:0] b,
                         input logic [15:0] amt, output logic [15:0] r, output logic w);
        logic [16:0] t;
        logic i, v, c, n, z, nz;
        {i, v, c, n, z} = mflags;
        r = 16'h0; w = 1'b0; nz = 1'b1;
        case (op)
            8'h05, 8'h1A: begin
                logic [15:0] bb;
                bb = (op == 8'h05) ? b : 16'h0001;
                t = a + bb; r = t[15:0]; c = t[16]; w = 1'b1;
                v = (a[15] == bb[15]) && (r[15] != a[15]);
            end
            8'h06, 8'h17, 8'h1B, 8'h1C: begin
                logic [15:0] aa, bb;
                aa = (op == 8'h1C) ? 16'h0 : a;
                bb = (op == 8'h1B) ? 16'h0001 : ((op == 8'h1C) ? a : b);
                r = aa - bb; c = (aa < bb); w = (op != 8'h17);
                v = (aa[15] != bb[15]) && (r[15] != aa[15]);
            end
            8'h12, 8'h13, 8'h14, 8'h19, 8'h18: begin
                r = (op == 8'h13) ? (a | b) : (op == 8'h14) ? (a ^ b) :
                    (op == 8'h19) ? ~a : (a & b);
                w = (op != 8'h18); v = 1'b0; c = 1'b0;
            end
            8'h15, 8'h16: begin
                r = a; c = 1'b0; v = 1'b0; w = 1'b1;
                for (int k = 0; k < 17 && k < amt; k++) begin
                    if (op == 8'h15) begin c = r[15]; r = r << 1; end
                    else begin c = r[0]; r = r >> 1; end
                end
            end
            8'h10: begin i = 1'b1; nz = 1'b0; end
            8'h11: begin i = 1'b0; nz = 1'b0; end
            default: nz = 1'b0;
        endcase
        if (nz) begin n = r[15]; z = (r == 16'h0); end
        mflags = {i, v, c, n, z};
    endtask

    task automatic apply(input logic [7:0] op, input logic [15:0] a, input logic [15:0] b,
                         input logic [15:0] amt);
        logic [15:0] er;
        logic ew;
        string tg;
        tg = tag_of(op);
        @(negedge clk);
        opcode = op; src_a = a; src_b = b; shamt = amt;
        model(op, a, b, amt, er, ew);
        #2;
        check({tg, " we"}, {31'b0, result_we}, {31'b0, ew});
        if (ew) check({tg, " result"}, {16'b0, result}, {16'b0, er});
        @(posedge clk);
        #2;
        // R8 and R11 layout checked together with the owning requirement
        check({tg, "/R8/R11 flags"}, {16'b0, flag_word}, {27'b0, mflags});
    endtask

    localparam logic [7:0] OPS [15] = '{8'h05, 8'h06, 8'h12, 8'h13, 8'h14, 8'h15, 8'h16,
                                       8'h17, 8'h18, 8'h19, 8'h1A, 8'h1B, 8'h1C, 8'h10, 8'h11};

    initial begin
        #(20 * 150000);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        mflags = 5'b0;
        repeat (3) @(posedge clk);
        #2;
        check("R1 reset", {16'b0, flag_word}, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;
        // directed corners
        apply(8'h05, 16'h7FFF, 16'h0001, 0);   // R2 overflow
        apply(8'h05, 16'hFFFF, 16'h0001, 0);   // R2 carry, zero
        apply(8'h06, 16'h0000, 16'h0001, 0);   // R3 borrow
        apply(8'h06, 16'h8000, 16'h0001, 0);   // R3 overflow
        apply(8'h17, 16'h1234, 16'h1234, 0);   // R4 equal
        apply(8'h18, 16'hF0F0, 16'h0F0F, 0);   // R4 zero test
        apply(8'h10, 16'h0, 16'h0, 0);         // R9 enable
        apply(8'h19, 16'hFFFF, 16'h0, 0);      // R5 not to zero
        apply(8'h15, 16'h8001, 0, 16'd0);      // R6 zero amount
        apply(8'h15, 16'h8001, 0, 16'd1);      // R6
        apply(8'h15, 16'h0001, 0, 16'd16);     // R6 last bit out
        apply(8'h16, 16'h8000, 0, 16'd16);     // R6
        apply(8'h16, 16'hFFFF, 0, 16'd17);     // R6 beyond
        apply(8'h16, 16'hFFFF, 0, 16'd15);     // R6
        apply(8'h1A, 16'h7FFF, 0, 0);          // R7 inc overflow
        apply(8'h1B, 16'h0000, 0, 0);          // R7 dec borrow
        apply(8'h1C, 16'h8000, 0, 0);          // R7 negate min
        apply(8'h1C, 16'h0000, 0, 0);          // R7 negate zero
        apply(8'h00, 16'h0, 16'h0, 0);         // R10 foreign
        apply(8'hFD, 16'h1, 16'h2, 0);         // R10 foreign
        apply(8'h11, 16'h0, 16'h0, 0);         // R9 disable
        for (int it = 0; it < 400; it++) begin
            logic [7:0] op;
            logic [15:0] a, b, s;
            op = ($urandom % 8 == 0) ? 8'($urandom) : OPS[$urandom % 15];
            a = ($urandom % 4 == 0) ? 16'h8000 : 16'($urandom);
            b = ($urandom % 4 == 0) ? 16'h7FFF : 16'($urandom);
            s = ($urandom % 2 == 0) ? 16'($urandom % 20) : 16'($urandom);
            apply(op, a, b, s);
        end
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule